// File: doc/BRIEF.md
# Serial DAC Write Sequencer

This block is a host-side controller for a 12-bit multiplying DAC with a serial input. A parallel code arrives on a valid/ready port. The block turns that code into the three line levels the converter needs: a data line, a serial clock and an active-low load strobe. It sends the word most significant bit first, one bit per rising clock edge. After the last edge it drops the load strobe for one pulse, which moves the converter's shift register into its output latch.

The converter's output latch is transparent while the load strobe is low. For that reason the sequencer keeps the serial clock low for the whole of every load pulse.

Every minimum timing limit is a parameter counted in system-clock cycles:
- data setup before a rising edge;
- data hold after a rising edge;
- clock low time;
- clock high time;
- load pulse width.

The low phase of each bit lasts the larger of the setup and clock-low limits. The high phase lasts the larger of the hold and clock-high limits.

A bipolar mode input is sampled when a word is accepted. When it is set, the incoming code is treated as a signed two's-complement sample and sent as offset binary. In offset binary the sign bit is inverted, so the signed value zero becomes code 2048.

Top module: `dac_serial_writer`

## Requirements
- R1: Out of reset the lines sit at their idle levels: serial clock 0, load strobe 1, data 0, done 0, and ready 1.
- R2: Ready is high only while idle. After a word is accepted (valid and ready both high at a clock edge), ready stays low until the cycle in which done is high.
- R3: With bipolar mode 0, the 12 data values seen at the rising serial-clock edges equal the accepted code, most significant bit first.
- R4: With bipolar mode 1, the word sent equals the accepted code with bit 11 inverted. For example, 0x000 is sent as 0x800 and 0x7FF is sent as 0xFFF.
- R5: Before each rising edge, the data line has held its value for at least SETUP_CYC cycles, and the clock has been low for at least CLK_LO_CYC cycles.
- R6: The clock stays high for at least the larger of CLK_HI_CYC and HOLD_CYC cycles, and the data line does not change while the clock is high.
- R7: Each accepted word produces exactly 12 rising serial-clock edges.
- R8: After the 12th edge, the load strobe goes low once, for exactly LOAD_CYC cycles, and the serial clock stays low throughout.
- R9: Done is high for exactly one cycle, in the first cycle that the load strobe is high again; ready is also high in that cycle.
- R10: A synchronous reset at any point of a transfer returns every line to its idle levels on the next clock edge. The next word is then sent correctly.
- R11: While a transfer runs, valid, the code and the bipolar mode are ignored; the word sent is the one captured when it was accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bipolar | input | 1 | 1: code is signed and is sent as offset binary |
| in_valid | input | 1 | Code on in_code is offered |
| in_code | input | 12 | Code to convert |
| in_ready | output | 1 | Sequencer is idle and takes a code |
| sdata | output | 1 | Serial data line to the converter |
| sclk | output | 1 | Serial clock; the converter samples on its rising edge |
| load_n | output | 1 | Active-low load strobe |
| done | output | 1 | One-cycle pulse when the load strobe returns high |

## Verification
All outputs are registered from the next-state value, so each one changes on the edge that moves the state:
- The first data bit appears on the clock edge that accepts the word.
- Each rising serial-clock edge follows the start of its bit by max(SETUP_CYC, CLK_LO_CYC) cycles.
- The load strobe falls max(CLK_HI_CYC, HOLD_CYC) cycles after the 12th rising edge.
- Done appears LOAD_CYC cycles after the load strobe falls.

The bench samples every output on the falling system clock, once per cycle. It measures each phase by counting samples between transitions, and it compares the lengths with the parameter minimums. It does not wait a fixed number of cycles. After a reset it checks the lines at the first sample following the reset edge.

// File: rtl/dac_serial_writer.sv
module dac_serial_writer #(
  parameter int WORD_W     = 12,
  parameter int SETUP_CYC  = 2,
  parameter int HOLD_CYC   = 1,
  parameter int CLK_HI_CYC = 3,
  parameter int CLK_LO_CYC = 2,
  parameter int LOAD_CYC   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bipolar,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_code,
  output logic              in_ready,
  output logic              sdata,
  output logic              sclk,
  output logic              load_n,
  output logic              done
);

  localparam int LO_RAW  = (SETUP_CYC > CLK_LO_CYC) ? SETUP_CYC : CLK_LO_CYC;
  localparam int HI_RAW  = (HOLD_CYC > CLK_HI_CYC) ? HOLD_CYC : CLK_HI_CYC;
  localparam int LO_PH   = (LO_RAW < 1) ? 1 : LO_RAW;
  localparam int HI_PH   = (HI_RAW < 1) ? 1 : HI_RAW;
  localparam int LD_PH   = (LOAD_CYC < 1) ? 1 : LOAD_CYC;
  localparam int MAX_A   = (LO_PH > HI_PH) ? LO_PH : HI_PH;
  localparam int CNT_MAX = (MAX_A > LD_PH) ? MAX_A : LD_PH;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int BIT_W   = $clog2(WORD_W + 1);
  localparam int MSB     = WORD_W - 1;

  typedef enum logic [1:0] {S_IDLE, S_LOW, S_HIGH, S_LOAD} phase_t;

  phase_t            st, st_n;
  logic [CNT_W-1:0]  cnt, cnt_n;
  logic [BIT_W-1:0]  left, left_n;
  logic [WORD_W-1:0] sh, sh_n;
  logic              done_n;

  assign in_ready = (st == S_IDLE);

  always_comb begin
    st_n   = st;
    cnt_n  = cnt;
    left_n = left;
    sh_n   = sh;
    done_n = 1'b0;
    case (st)
      S_IDLE: begin
        if (in_valid) begin
          st_n   = S_LOW;
          cnt_n  = CNT_W'(LO_PH - 1);
          left_n = BIT_W'(WORD_W - 1);
          sh_n   = bipolar ? {~in_code[MSB], in_code[MSB-1:0]} : in_code;
        end
      end
      S_LOW: begin
        if (cnt == '0) begin
          st_n  = S_HIGH;
          cnt_n = CNT_W'(HI_PH - 1);
        end else begin
          cnt_n = cnt - 1'b1;
        end
      end
      S_HIGH: begin
        if (cnt != '0) begin
          cnt_n = cnt - 1'b1;
        end else if (left == '0) begin
          st_n  = S_LOAD;
          cnt_n = CNT_W'(LD_PH - 1);
        end else begin
          st_n   = S_LOW;
          cnt_n  = CNT_W'(LO_PH - 1);
          left_n = left - 1'b1;
          sh_n   = {sh[MSB-1:0], 1'b0};
        end
      end
      S_LOAD: begin
        if (cnt == '0) begin
          st_n   = S_IDLE;
          done_n = 1'b1;
        end else begin
          cnt_n = cnt - 1'b1;
        end
      end
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_IDLE;
      cnt    <= '0;
      left   <= '0;
      sh     <= '0;
      sclk   <= 1'b0;
      load_n <= 1'b1;
      sdata  <= 1'b0;
      done   <= 1'b0;
    end else begin
      st     <= st_n;
      cnt    <= cnt_n;
      left   <= left_n;
      sh     <= sh_n;
      sclk   <= (st_n == S_HIGH);
      load_n <= (st_n != S_LOAD);
      sdata  <= ((st_n == S_LOW) || (st_n == S_HIGH)) ? sh_n[MSB] : 1'b0;
      done   <= done_n;
    end
  end

endmodule

// File: rtl/dac_serial_writer_chk.sv
module dac_serial_writer_chk (
  input logic clk,
  input logic rst,
  input logic in_valid,
  input logic in_ready,
  input logic sdata,
  input logic sclk,
  input logic load_n,
  input logic done
);

  assert_idle_after_reset_R1: assert property (@(posedge clk)
    $past(rst) |-> (!sclk && load_n && !sdata && !done && in_ready));

  assert_ready_drops_on_accept_R2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready);

  assert_ready_only_idle_R2: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> (!sclk && load_n));

  assert_setup_at_rise_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(sclk) |-> $stable(sdata));

  assert_hold_while_high_R6: assert property (@(posedge clk) disable iff (rst)
    (sclk && $past(sclk)) |-> $stable(sdata));

  assert_clock_idle_in_load_R8: assert property (@(posedge clk) disable iff (rst)
    !load_n |-> !sclk);

  assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_on_load_release_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> (load_n && $past(!load_n) && in_ready));

endmodule

bind dac_serial_writer dac_serial_writer_chk chk_i (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .sdata    (sdata),
  .sclk     (sclk),
  .load_n   (load_n),
  .done     (done)
);

// File: tb/dac_serial_writer_tb_top.sv
module dac_serial_writer_tb_top;

  localparam int PERIOD  = 10;
  localparam int T_SETUP = 2;
  localparam int T_HOLD  = 1;
  localparam int T_HI    = 3;
  localparam int T_LO    = 2;
  localparam int T_LOAD  = 3;
  localparam int T_HIPH  = (T_HI > T_HOLD) ? T_HI : T_HOLD;
  localparam int NVEC    = 8;

  localparam logic [24:0] VEC [NVEC] = '{
    {1'b0, 12'hA5C, 12'hA5C},
    {1'b0, 12'h001, 12'h001},
    {1'b0, 12'h800, 12'h800},
    {1'b1, 12'h000, 12'h800},
    {1'b1, 12'hFFF, 12'h7FF},
    {1'b1, 12'h7FF, 12'hFFF},
    {1'b1, 12'h800, 12'h000},
    {1'b1, 12'h3C6, 12'hBC6}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bipolar = 1'b0;
  logic        in_valid = 1'b0;
  logic [11:0] in_code = '0;
  logic        in_ready, sdata, sclk, load_n, done;

  int checks = 0;
  int fails  = 0;

  always #(PERIOD/2) clk = ~clk;

  dac_serial_writer #(
    .WORD_W(12), .SETUP_CYC(T_SETUP), .HOLD_CYC(T_HOLD),
    .CLK_HI_CYC(T_HI), .CLK_LO_CYC(T_LO), .LOAD_CYC(T_LOAD)
  ) dut_i (
    .clk(clk), .rst(rst), .bipolar(bipolar), .in_valid(in_valid),
    .in_code(in_code), .in_ready(in_ready), .sdata(sdata), .sclk(sclk),
    .load_n(load_n), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [11:0] code, input logic bip,
                      input logic [11:0] expw, input bit poke);
    int rises = 0, lowrun = 0, highrun = 0, datarun = 0, loadrun = 0, n = 0;
    int min_setup = 999, min_low = 999, min_high = 999;
    logic [11:0] word = '0;
    logic psclk = 1'b0, pdata = 1'b0;
    bit ok_hold = 1, ok_ready = 1, ok_load = 1, ok_12 = 1, got_done = 0;
    bit ok_done_lines = 1;
    @(negedge clk);
    in_code = code; bipolar = bip; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    if (poke) begin
      in_valid = 1'b1; in_code = ~code; bipolar = ~bip;
    end
    while (!got_done && n < 2000) begin
      n++;
      if (done) begin
        got_done = 1;
        ok_done_lines = load_n && in_ready;
      end else if (in_ready) begin
        ok_ready = 0;
      end
      if (sdata == pdata) datarun++; else datarun = 1;
      if (!load_n) begin
        loadrun++;
        if (sclk) ok_load = 0;
        if (rises != 12) ok_12 = 0;
      end
      if (sclk && !psclk) begin
        rises++;
        word = {word[10:0], sdata};
        if (datarun - 1 < min_setup) min_setup = datarun - 1;
        if (lowrun < min_low) min_low = lowrun;
        highrun = 0;
      end
      if (!sclk && psclk) begin
        if (highrun < min_high) min_high = highrun;
        lowrun = 0;
      end
      if (sclk) begin
        highrun++;
        if (psclk && sdata != pdata) ok_hold = 0;
      end else begin
        lowrun++;
      end
      psclk = sclk; pdata = sdata;
      if (poke && n == 4) begin
        in_valid = 1'b0; in_code = code; bipolar = bip;
      end
      if (!got_done) @(negedge clk);
    end
    chk(got_done && ok_done_lines, "R9 done with load high and ready", int'(ok_done_lines), 1);
    chk(rises == 12, "R7 rising edge count", rises, 12);
    if (poke)     chk(word == expw, "R11 word unaffected by busy inputs", word, expw);
    else if (bip) chk(word == expw, "R4 offset binary word", word, expw);
    else          chk(word == expw, "R3 MSB-first word", word, expw);
    chk(min_setup >= T_SETUP, "R5 data setup cycles", min_setup, T_SETUP);
    chk(min_low >= T_LO, "R5 clock low cycles", min_low, T_LO);
    chk(min_high >= T_HIPH, "R6 clock high cycles", min_high, T_HIPH);
    chk(ok_hold, "R6 data stable while clock high", int'(ok_hold), 1);
    chk(ok_load && ok_12, "R8 clock idle in load, load after 12 edges", int'(ok_load && ok_12), 1);
    chk(loadrun == T_LOAD, "R8 load pulse width", loadrun, T_LOAD);
    chk(ok_ready, "R2 ready low while busy", int'(ok_ready), 1);
    @(negedge clk);
    chk(!done, "R9 done lasts one cycle", int'(done), 0);
  endtask

  task automatic idle_lines(input string req);
    chk({sclk, load_n, sdata, done, in_ready} == 5'b01001, req,
        int'({sclk, load_n, sdata, done, in_ready}), 5'b01001);
  endtask

  initial begin
    #(PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    idle_lines("R1 idle levels after reset");
    repeat (4) @(negedge clk);
    idle_lines("R1 idle levels hold with valid low");

    for (int i = 0; i < NVEC; i++)
      send(VEC[i][23:12], VEC[i][24], VEC[i][11:0], 1'b0);

    send(12'h5A3, 1'b0, 12'h5A3, 1'b1);
    send(12'h123, 1'b1, 12'h923, 1'b1);

    // R10: reset during shifting
    @(negedge clk);
    in_code = 12'hFFF; bipolar = 1'b0; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (7) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    idle_lines("R10 idle after reset mid-shift");
    rst = 1'b0;
    send(12'h6E1, 1'b0, 12'h6E1, 1'b0);

    // R10: reset during load pulse
    @(negedge clk);
    in_code = 12'h0F0; bipolar = 1'b0; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    for (int k = 0; k < 400 && load_n; k++) @(negedge clk);
    chk(!load_n, "R8 load strobe reached", int'(load_n), 0);
    rst = 1'b1;
    @(negedge clk);
    idle_lines("R10 idle after reset in load");
    rst = 1'b0;
    send(12'h0F0, 1'b1, 12'h8F0, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule